// File: doc/BRIEF.md
# Interrupt Mask and Status Controller

This block gathers four interrupt request lines for a small processor core and decides which one, if any, is offered to the core. There is one non-maskable line and three maskable vectored lines of descending rank, named high, middle and low here. The high line and the non-maskable line are captured on a rising edge. The middle and low lines are level-sensitive. The maskable lines are offered only while a global enable flip-flop is set and their own mask bit is clear. The block drives the winning request together with its fixed 16-bit vector address. When the core accepts that request by pulsing an acknowledge, the global enable is cleared. An acknowledge of an edge-captured line also clears its capture latch.

Software reaches the block through four single-cycle commands. An enable command sets the global enable and a disable command clears it. A mask-write command takes a control byte from the accumulator. That byte can reload the three masks, clear the high-line latch and update a one-bit serial output. The packed status byte is always present on an output port, so a mask-read command has only to copy it. It carries the serial input pin, the three pending levels, the global enable and the masks.

Top module: `irq_mask_ctrl`

## Requirements
- R1: Reset clears the global enable, both capture latches and the serial output, and sets all three masks to 1, so the status byte reads 07h, `irqOut` is 0 and `vecAddr` is 0000h.
- R2: On a mask write whose bit 3 is 1, the masks take bits 2, 1 and 0 of the byte (high, middle, low; 1 means masked). When bit 3 is 0 the masks keep their value.
- R3: A mask write with bit 4 set clears the high-line latch whatever bit 3 holds. A rising edge on `reqHi` in the same cycle wins, and the latch is left set.
- R4: A mask write with bit 6 set loads bit 7 into `serialOut`. When bit 6 is 0, `serialOut` is unchanged.
- R5: The status byte is {serialIn, high pending, middle pending, low pending, global enable, high mask, middle mask, low mask}, from bit 7 down to bit 0. A pending bit shows the request whether or not its level is masked.
- R6: `enCmd` sets and `disCmd` clears the global enable, and disable wins when both arrive together. Neither command changes a pending non-maskable request.
- R7: The high line is latched on a rising edge of `reqHi` and stays latched while the input is held. The middle and low lines follow `reqMid` and `reqLo` directly.
- R8: A rising edge of `trapReq` latches a non-maskable request, which is offered regardless of masks and of the global enable.
- R9: Priority is non-maskable, then high, then middle, then low. Their vectors are 0024h, 003Ch, 0034h and 002Ch. `irqOut` is 1 exactly when one of them is offered, and `vecAddr` is 0000h when none is.
- R10: `ack` while `irqOut` is 1 clears the global enable, which wins over a simultaneous `enCmd`. It also clears the latch of an accepted high or non-maskable request. `ack` while `irqOut` is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| maskWr | input | 1 | Mask-write command strobe |
| wrData | input | 8 | Control byte for a mask write |
| enCmd | input | 1 | Set global enable |
| disCmd | input | 1 | Clear global enable |
| reqHi | input | 1 | High-rank maskable request, edge-captured |
| reqMid | input | 1 | Middle-rank maskable request, level |
| reqLo | input | 1 | Low-rank maskable request, level |
| trapReq | input | 1 | Non-maskable request, edge-captured |
| serialIn | input | 1 | Serial input pin, reported in status |
| ack | input | 1 | Core accepts the offered request |
| serialOut | output | 1 | Serial output bit |
| statusByte | output | 8 | Packed status for a mask read |
| irqOut | output | 1 | A request is offered |
| vecAddr | output | 16 | Vector of the offered request |

## Verification
The stimulus table aims at the interactions where a wrong design drifts without any visible crash. These are:
- a mask write with bit 3 clear, which a careless design would still use to reload the masks;
- a latch clear that collides with a fresh rising edge, where the new request would be lost;
- enable and disable in the same cycle;
- an acknowledge together with an enable, which would leave interrupts re-armed after acceptance.

The table holds `reqHi` and `trapReq` high across several steps. A design that latches on level rather than edge would then re-raise a request it had just acknowledged. A masked, disabled non-maskable request checks that masking and disable never hide that line. An acknowledge with nothing offered checks that a stray acknowledge leaves the status byte untouched.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int LEVELS = 3;

  // strobes from the control unit to the state datapath
  typedef struct packed {
    logic loadMask;
    logic loadSerial;
    logic clrHi;
    logic clrTrap;
    logic setGie;
    logic clrGie;
  } ctrlStrb_t;
endpackage

// File: rtl/irq_state_path.sv
module irq_state_path
  import irq_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [LEVELS-1:0] maskIn,
  input  logic              serialBit,
  input  logic              reqHi,
  input  logic              trapIn,
  output logic [LEVELS-1:0] maskQ,
  output logic              gieQ,
  output logic              hiLatchQ,
  output logic              trapLatchQ,
  output logic              serialQ
);
  logic hiPrev, trapPrev;
  logic hiRise, trapRise;

  assign hiRise   = reqHi & ~hiPrev;
  assign trapRise = trapIn & ~trapPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiPrev     <= 1'b0;
      trapPrev   <= 1'b0;
      hiLatchQ   <= 1'b0;
      trapLatchQ <= 1'b0;
      maskQ      <= '1;
      gieQ       <= 1'b0;
      serialQ    <= 1'b0;
    end else begin
      hiPrev   <= reqHi;
      trapPrev <= trapIn;
      if (hiRise)            hiLatchQ <= 1'b1;
      else if (strb.clrHi)   hiLatchQ <= 1'b0;
      if (trapRise)          trapLatchQ <= 1'b1;
      else if (strb.clrTrap) trapLatchQ <= 1'b0;
      if (strb.loadMask)     maskQ <= maskIn;
      if (strb.loadSerial)   serialQ <= serialBit;
      if (strb.clrGie)       gieQ <= 1'b0;
      else if (strb.setGie)  gieQ <= 1'b1;
    end
  end

  // R7
  hi_edge_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiRise |=> hiLatchQ);
  // R8
  trap_edge_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapRise |=> trapLatchQ);
  // R6
  gie_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrGie |=> !gieQ);
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
  import irq_mask_pkg::*;
#(
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_TRAP = 16'h0024,
  parameter logic [15:0] VEC_HI   = 16'h003C,
  parameter logic [15:0] VEC_MID  = 16'h0034,
  parameter logic [15:0] VEC_LO   = 16'h002C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              maskWr,
  input  logic [7:0]        wrData,
  input  logic              enCmd,
  input  logic              disCmd,
  input  logic              reqMid,
  input  logic              reqLo,
  input  logic              serialIn,
  input  logic              ack,
  input  logic [LEVELS-1:0] maskQ,
  input  logic              gieQ,
  input  logic              hiLatchQ,
  input  logic              trapLatchQ,
  output ctrlStrb_t         strb,
  output logic              irqOut,
  output logic [VEC_W-1:0]  vecAddr,
  output logic [7:0]        statusByte
);
  localparam int BIT_SER_VAL = 7;
  localparam int BIT_SER_EN  = 6;
  localparam int BIT_HI_CLR  = 4;
  localparam int BIT_MSK_EN  = 3;
  localparam int SRCS        = LEVELS + 1;

  localparam logic [VEC_W-1:0] VEC_TAB [SRCS] = '{
    VEC_LO[VEC_W-1:0], VEC_MID[VEC_W-1:0], VEC_HI[VEC_W-1:0], VEC_TRAP[VEC_W-1:0]};

  logic [LEVELS-1:0] pend, avail;
  logic [SRCS-1:0]   req, grant;
  logic              take;
  wire               unusedSpare = wrData[5];

  assign pend  = {hiLatchQ, reqMid, reqLo};
  assign avail = pend & ~maskQ & {LEVELS{gieQ}};
  assign req   = {trapLatchQ, avail};

  // fixed priority, highest index wins
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = SRCS - 1; i >= 0; i--) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    vecAddr = '0;
    for (int i = 0; i < SRCS; i++)
      if (grant[i]) vecAddr = VEC_TAB[i];
  end

  assign irqOut = |grant;
  assign take   = ack & irqOut;

  assign strb.loadMask   = maskWr & wrData[BIT_MSK_EN];
  assign strb.loadSerial = maskWr & wrData[BIT_SER_EN];
  assign strb.clrHi      = (maskWr & wrData[BIT_HI_CLR]) | (take & grant[LEVELS-1]);
  assign strb.clrTrap    = take & grant[LEVELS];
  assign strb.setGie     = enCmd;
  assign strb.clrGie     = disCmd | take;

  assign statusByte = {serialIn, pend, gieQ, maskQ};

  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  // R8
  trap_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapLatchQ |-> (irqOut && vecAddr == VEC_TRAP[VEC_W-1:0]));
  // R9
  quiet_when_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!gieQ && !trapLatchQ) |-> !irqOut);
  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskWr && wrData[BIT_MSK_EN]) |=> maskQ == $past(wrData[LEVELS-1:0]));
  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(maskWr && wrData[BIT_MSK_EN]) |=> $stable(maskQ));
  // R10
  accept_disables_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ack && irqOut) |=> !gieQ);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int          VEC_W    = 16,
  parameter logic [15:0] VEC_TRAP = 16'h0024,
  parameter logic [15:0] VEC_HI   = 16'h003C,
  parameter logic [15:0] VEC_MID  = 16'h0034,
  parameter logic [15:0] VEC_LO   = 16'h002C
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             maskWr,
  input  logic [7:0]       wrData,
  input  logic             enCmd,
  input  logic             disCmd,
  input  logic             reqHi,
  input  logic             reqMid,
  input  logic             reqLo,
  input  logic             trapReq,
  input  logic             serialIn,
  input  logic             ack,
  output logic             serialOut,
  output logic [7:0]       statusByte,
  output logic             irqOut,
  output logic [VEC_W-1:0] vecAddr
);
  ctrlStrb_t         strb;
  logic [LEVELS-1:0] maskQ;
  logic              gieQ, hiLatchQ, trapLatchQ;

  irq_ctrl_unit #(
    .VEC_W(VEC_W), .VEC_TRAP(VEC_TRAP), .VEC_HI(VEC_HI),
    .VEC_MID(VEC_MID), .VEC_LO(VEC_LO)
  ) ctrl (
    .clk(clk), .rstN(rstN), .maskWr(maskWr), .wrData(wrData),
    .enCmd(enCmd), .disCmd(disCmd), .reqMid(reqMid), .reqLo(reqLo),
    .serialIn(serialIn), .ack(ack), .maskQ(maskQ), .gieQ(gieQ),
    .hiLatchQ(hiLatchQ), .trapLatchQ(trapLatchQ), .strb(strb),
    .irqOut(irqOut), .vecAddr(vecAddr), .statusByte(statusByte)
  );

  irq_state_path path (
    .clk(clk), .rstN(rstN), .strb(strb), .maskIn(wrData[LEVELS-1:0]),
    .serialBit(wrData[7]), .reqHi(reqHi), .trapIn(trapReq),
    .maskQ(maskQ), .gieQ(gieQ), .hiLatchQ(hiLatchQ),
    .trapLatchQ(trapLatchQ), .serialQ(serialOut)
  );
endmodule

// File: tb/irq_mask_ctrl_test.sv
module irq_mask_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic maskWr = 1'b0, enCmd = 1'b0, disCmd = 1'b0, ack = 1'b0;
  logic reqHi = 1'b0, reqMid = 1'b0, reqLo = 1'b0, trapReq = 1'b0, serialIn = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic        serialOut, irqOut;
  logic [7:0]  statusByte;
  logic [15:0] vecAddr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_mask_ctrl uut (
    .clk(clk), .rstN(rstN), .maskWr(maskWr), .wrData(wrData), .enCmd(enCmd),
    .disCmd(disCmd), .reqHi(reqHi), .reqMid(reqMid), .reqLo(reqLo),
    .trapReq(trapReq), .serialIn(serialIn), .ack(ack), .serialOut(serialOut),
    .statusByte(statusByte), .irqOut(irqOut), .vecAddr(vecAddr)
  );

  // ctl = {en, dis, hi, mid, lo, trap, ack}
  function automatic logic [42:0] st(input logic mw, input logic [7:0] wd,
      input logic [6:0] ctl, input logic sin, input logic [7:0] stat,
      input logic irq, input logic sout, input logic [15:0] vec);
    return {mw, wd, ctl, sin, stat, irq, sout, vec};
  endfunction

  localparam int NSTEP = 31;
  localparam logic [42:0] STEPS [NSTEP] = '{
    st(0, 8'h00, 7'b0000000, 0, 8'h07, 0, 0, 16'h0000), // R1 idle
    st(0, 8'h00, 7'b1000000, 0, 8'h0F, 0, 0, 16'h0000), // R6 enable
    st(1, 8'h08, 7'b0000000, 0, 8'h08, 0, 0, 16'h0000), // R2 unmask all
    st(0, 8'h00, 7'b0000100, 0, 8'h18, 1, 0, 16'h002C), // R7 low level
    st(0, 8'h00, 7'b0001100, 0, 8'h38, 1, 0, 16'h0034), // R9 mid over low
    st(0, 8'h00, 7'b0011100, 0, 8'h78, 1, 0, 16'h003C), // R7 hi edge
    st(0, 8'h00, 7'b0011110, 0, 8'h78, 1, 0, 16'h0024), // R8 trap edge
    st(0, 8'h00, 7'b0011111, 0, 8'h70, 0, 0, 16'h0000), // R10 ack trap
    st(0, 8'h00, 7'b1011110, 0, 8'h78, 1, 0, 16'h003C), // R8 held trap no re-latch
    st(0, 8'h00, 7'b0011111, 0, 8'h30, 0, 0, 16'h0000), // R10 ack hi clears latch
    st(0, 8'h00, 7'b1011100, 0, 8'h38, 1, 0, 16'h0034), // R7 held hi no re-latch
    st(1, 8'h0A, 7'b0011100, 0, 8'h3A, 1, 0, 16'h002C), // R2 mask mid
    st(1, 8'h03, 7'b0011100, 0, 8'h3A, 1, 0, 16'h002C), // R2 bit3 clear ignored
    st(0, 8'h00, 7'b0001100, 0, 8'h3A, 1, 0, 16'h002C), // hi low
    st(0, 8'h00, 7'b0011100, 0, 8'h7A, 1, 0, 16'h003C), // R7 new hi edge
    st(1, 8'h10, 7'b0011100, 0, 8'h3A, 1, 0, 16'h002C), // R3 clear hi latch
    st(1, 8'hC0, 7'b0011100, 1, 8'hBA, 1, 1, 16'h002C), // R4 serial load, R5 sin
    st(1, 8'h00, 7'b0011100, 0, 8'h3A, 1, 1, 16'h002C), // R4 serial hold
    st(1, 8'h40, 7'b0011100, 0, 8'h3A, 1, 0, 16'h002C), // R4 serial 0
    st(0, 8'h00, 7'b1111100, 0, 8'h32, 0, 0, 16'h0000), // R6 dis wins over en
    st(1, 8'h0F, 7'b1011100, 0, 8'h3F, 0, 0, 16'h0000), // R5 masked still pending
    st(0, 8'h00, 7'b0011110, 0, 8'h3F, 1, 0, 16'h0024), // R8 trap ignores masks
    st(0, 8'h00, 7'b0111110, 0, 8'h37, 1, 0, 16'h0024), // R6 dis leaves trap
    st(0, 8'h00, 7'b0011111, 0, 8'h37, 0, 0, 16'h0000), // R10 ack trap gie off
    st(0, 8'h00, 7'b0011101, 0, 8'h37, 0, 0, 16'h0000), // R10 stray ack
    st(1, 8'h08, 7'b1000000, 0, 8'h08, 0, 0, 16'h0000), // R6 enable
    st(1, 8'h18, 7'b0010000, 0, 8'h48, 1, 0, 16'h003C), // R3 edge beats clear
    st(1, 8'h0C, 7'b0010000, 0, 8'h4C, 0, 0, 16'h0000), // R2 mask hi
    st(0, 8'h00, 7'b0010001, 0, 8'h4C, 0, 0, 16'h0000), // R10 ack with nothing offered
    st(1, 8'h08, 7'b0010000, 0, 8'h48, 1, 0, 16'h003C), // R2 unmask hi
    st(0, 8'h00, 7'b1010001, 0, 8'h00, 0, 0, 16'h0000)  // R10 ack beats enable
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [42:0] e);
    maskWr   = e[42];
    wrData   = e[41:34];
    {enCmd, disCmd, reqHi, reqMid, reqLo, trapReq, ack} = e[33:27];
    serialIn = e[26];
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #5;
    check("R1 reset status", 16'(statusByte), 16'h0007);
    check("R1 reset irq", 16'(irqOut), 16'h0000);
    check("R1 reset serial", 16'(serialOut), 16'h0000);
    check("R1 reset vector", vecAddr, 16'h0000);

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      drive(STEPS[i]);
      @(posedge clk);
      #5;
      check($sformatf("R5 status step %0d", i), 16'(statusByte), 16'(STEPS[i][25:18]));
      check($sformatf("R9 irq step %0d", i), 16'(irqOut), 16'(STEPS[i][17]));
      check($sformatf("R4 serial step %0d", i), 16'(serialOut), 16'(STEPS[i][16]));
      check($sformatf("R9 vector step %0d", i), vecAddr, STEPS[i][15:0]);
    end

    // R1: reset in the middle of activity returns to the reset state
    @(negedge clk);
    drive(st(1, 8'hC8, 7'b1000100, 0, 8'h00, 0, 0, 16'h0000));
    @(negedge clk);
    drive(43'd0);
    rstN = 1'b0;
    @(posedge clk);
    #5;
    check("R1 mid-run reset status", 16'(statusByte), 16'h0007);
    check("R1 mid-run reset serial", 16'(serialOut), 16'h0000);
    check("R1 mid-run reset irq", 16'(irqOut), 16'h0000);
    @(negedge clk) rstN = 1'b1;
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule